// File: doc/BRIEF.md
# Thread Context Pull to Reporting Line

This unit saves the interrupt context of one hardware thread into memory and then invalidates that context. A pull command names a thread. The unit takes a snapshot of selected words from that thread's OS, pool and physical context rings in the cycle it accepts the command. It then writes the snapshot, one byte per cycle, into the odd 128-byte half of a 256-byte reporting cache-line pair. Each copied word sits at the same offset inside the odd line that it has inside the thread context area. When the last byte has been written, the unit pulses a done flag. In that same cycle it strobes the clear lines for the valid bits of all three rings of that thread.

The write stream carries a byte offset within the line pair and one data byte. The memory or bus agent that receives the stream decides where the line pair lives. A new pull is accepted only while the unit is idle. A request made while the unit is busy has no effect.

Top module: `ctx_pull_report`

## Requirements
- R1: After reset, busy, wr_en, done and all clear strobes are 0.
- R2: A pull_req seen at a clock edge while busy is 0 is accepted. In the next cycle busy is 1 and the first byte is presented with wr_en=1. busy then stays 1 through the done cycle.
- R3: Every write targets the odd line (wr_addr bit 7 = 1, offsets 0x80 to 0xFF). Each pull writes exactly 17 bytes and never writes the even line.
- R4: Bytes are written on consecutive cycles in ascending offset order. The offsets are: OS word 0 at 0x90-0x93, OS word 2 at 0x98-0x9B, pool word 2 at 0xA8-0xAB, physical word 0 at 0xB0-0xB3, and bits 31:24 of physical word 2 at 0xB8. These are ring offsets 0x10 (OS), 0x20 (pool) and 0x30 (physical), plus word offsets 0 and 8, plus 0x80.
- R5: Words are big-endian: bits 31:24 go to the lowest offset of each word and bits 7:0 to the highest.
- R6: The data written are the context words of the pulled thread as they stood at the accepting edge. Changes to the context inputs during the stream have no effect on the bytes written.
- R7: done is 1 for exactly one cycle, the cycle right after the last byte. In that cycle clr_os_valid, clr_pool_valid and clr_phys_valid each carry a one-hot bit for the pulled thread. All three strobes are 0 in every other cycle. busy is 0 in the cycle after done.
- R8: The valid bits are word 2 bit 31 of each ring. The snapshot records them in their pre-pull state, and the clear strobes cause them to read 0 after the pull.
- R9: A pull_req made while busy is 1 is ignored: no extra bytes are written, and the stream in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pull_req | input | 1 | Pull command |
| pull_thread | input | TW | Thread index of the pull |
| os_word0 | input | 32*NTHREADS | OS ring word 0, one 32-bit slice per thread |
| os_word2 | input | 32*NTHREADS | OS ring word 2 (bit 31 = valid) |
| pool_word2 | input | 32*NTHREADS | Pool ring word 2 (bit 31 = valid) |
| phys_word0 | input | 32*NTHREADS | Physical ring word 0 |
| phys_word2 | input | 32*NTHREADS | Physical ring word 2 (bit 31 = valid) |
| busy | output | 1 | Pull in progress; new requests ignored |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 8 | Byte offset within the 256-byte line pair |
| wr_data | output | 8 | Byte written |
| done | output | 1 | One-cycle pulse after the last byte |
| clr_os_valid | output | NTHREADS | Clear strobe for the OS valid bit, per thread |
| clr_pool_valid | output | NTHREADS | Clear strobe for the pool valid bit, per thread |
| clr_phys_valid | output | NTHREADS | Clear strobe for the physical valid bit, per thread |

## Verification
Each word of the context is filled with a distinct byte pattern. A shuffled byte or a swapped word then shows up as a wrong value at a known offset, which separates endianness faults from offset faults. An all-ones context on the lowest thread and a distinct pattern on the highest thread expose errors in thread selection and at the slice edges. One run changes the context inputs during the stream, which separates a snapshot taken at acceptance from live sampling. Another run raises a pull for a different thread mid-stream, which shows whether busy really holds the request off. A check of the valid bits after each pull confirms that the report carried the old valid state and that the clears reached only the pulled thread.

// File: rtl/ctx_pull_report.sv
module ctx_pull_report #(
  parameter int NTHREADS = 4,
  parameter int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pull_req,
  input  logic [TW-1:0]         pull_thread,
  input  logic [32*NTHREADS-1:0] os_word0,
  input  logic [32*NTHREADS-1:0] os_word2,
  input  logic [32*NTHREADS-1:0] pool_word2,
  input  logic [32*NTHREADS-1:0] phys_word0,
  input  logic [32*NTHREADS-1:0] phys_word2,
  output logic                  busy,
  output logic                  wr_en,
  output logic [7:0]            wr_addr,
  output logic [7:0]            wr_data,
  output logic                  done,
  output logic [NTHREADS-1:0]   clr_os_valid,
  output logic [NTHREADS-1:0]   clr_pool_valid,
  output logic [NTHREADS-1:0]   clr_phys_valid
);

  localparam logic [7:0] ODD_LINE  = 8'h80;
  localparam logic [7:0] RING_OS   = 8'h10;
  localparam logic [7:0] RING_POOL = 8'h20;
  localparam logic [7:0] RING_PHYS = 8'h30;
  localparam logic [7:0] OFS_W0    = 8'h00;
  localparam logic [7:0] OFS_W2    = 8'h08;
  localparam int NBYTES = 17;
  localparam int SNAPW  = 8 * NBYTES;
  localparam int IW     = $clog2(NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_FIN} state_t;

  state_t            state;
  logic [SNAPW-1:0]  snap;
  logic [IW-1:0]     idx;
  logic [TW-1:0]     thr;
  logic [7:0]        base;

  wire accept = (state == S_IDLE) && pull_req;
  wire last   = (state == S_SEND) && (idx == IW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      snap  <= '0;
      idx   <= '0;
      thr   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_SEND;
          idx   <= '0;
          thr   <= pull_thread;
          snap  <= {os_word0[32*pull_thread +: 32],
                    os_word2[32*pull_thread +: 32],
                    pool_word2[32*pull_thread +: 32],
                    phys_word0[32*pull_thread +: 32],
                    phys_word2[32*pull_thread+24 +: 8]};
        end
        S_SEND: begin
          snap <= snap << 8;
          idx  <= idx + 1'b1;
          if (last) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (idx[IW-1:2])
      3'd0:    base = ODD_LINE + RING_OS   + OFS_W0;
      3'd1:    base = ODD_LINE + RING_OS   + OFS_W2;
      3'd2:    base = ODD_LINE + RING_POOL + OFS_W2;
      3'd3:    base = ODD_LINE + RING_PHYS + OFS_W0;
      default: base = ODD_LINE + RING_PHYS + OFS_W2;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign wr_en   = (state == S_SEND);
  assign wr_addr = wr_en ? (base + {6'd0, idx[1:0]}) : 8'h00;
  assign wr_data = wr_en ? snap[SNAPW-1 -: 8] : 8'h00;
  assign done    = (state == S_FIN);

  genvar g;
  generate
    for (g = 0; g < NTHREADS; g++) begin : g_clr
      assign clr_os_valid[g]   = done && (thr == TW'(g));
      assign clr_pool_valid[g] = done && (thr == TW'(g));
      assign clr_phys_valid[g] = done && (thr == TW'(g));
    end
  endgenerate

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> !busy && !wr_en && !done);

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pull_req) |=> (busy && wr_en));

  a_r2_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r3_odd_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr[7]);

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr)));

  a_r7_done_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(clr_os_valid) == 1 && clr_os_valid == clr_pool_valid
              && clr_os_valid == clr_phys_valid));

  a_r7_clr_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($onehot0(clr_os_valid) && clr_os_valid == '0
               && clr_pool_valid == '0 && clr_phys_valid == '0));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(clr_os_valid));

endmodule

// File: tb/test_ctx_pull_report.sv
module test_ctx_pull_report;
  localparam int NT = 4;
  localparam int TW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic pull_req = 0;
  logic [TW-1:0] pull_thread = '0;
  logic [31:0] os0 [NT];
  logic [31:0] os2 [NT];
  logic [31:0] pl2 [NT];
  logic [31:0] ph0 [NT];
  logic [31:0] ph2 [NT];
  logic [32*NT-1:0] os0_b, os2_b, pl2_b, ph0_b, ph2_b;
  logic busy, wr_en, done;
  logic [7:0] wr_addr, wr_data;
  logic [NT-1:0] clr_os, clr_pool, clr_phys;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      os0_b[32*i +: 32] = os0[i];
      os2_b[32*i +: 32] = os2[i];
      pl2_b[32*i +: 32] = pl2[i];
      ph0_b[32*i +: 32] = ph0[i];
      ph2_b[32*i +: 32] = ph2[i];
    end
  end

  ctx_pull_report #(.NTHREADS(NT)) i_ctx_pull_report (
    .clk(clk), .rst_n(rst_n), .pull_req(pull_req), .pull_thread(pull_thread),
    .os_word0(os0_b), .os_word2(os2_b), .pool_word2(pl2_b),
    .phys_word0(ph0_b), .phys_word2(ph2_b),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .clr_os_valid(clr_os), .clr_pool_valid(clr_pool),
    .clr_phys_valid(clr_phys));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input int i);
    if (i < 4)       return 8'h90 + 8'(i);
    else if (i < 8)  return 8'h98 + 8'(i - 4);
    else if (i < 12) return 8'hA8 + 8'(i - 8);
    else if (i < 16) return 8'hB0 + 8'(i - 12);
    else             return 8'hB8;
  endfunction

  task automatic load_ctx(input int t, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d,
                          input logic [31:0] e);
    os0[t] = a; os2[t] = b; pl2[t] = c; ph0[t] = d; ph2[t] = e;
  endtask

  // mode 0 plain, 1 change context mid-stream (R6), 2 pull while busy (R9)
  task automatic run_pull(input int t, input int mode);
    logic [31:0] e [5];
    logic [31:0] w;
    int other;
    e[0] = os0[t]; e[1] = os2[t]; e[2] = pl2[t]; e[3] = ph0[t]; e[4] = ph2[t];
    @(negedge clk);
    pull_req = 1; pull_thread = TW'(t);
    @(negedge clk);
    pull_req = 0;
    check(busy === 1'b1, "R2 busy after accept", 32'(busy), 1);
    for (int i = 0; i < 17; i++) begin
      w = e[i / 4];
      check(wr_en === 1'b1, "R2 R3 write strobe", 32'(wr_en), 1);
      check(wr_addr === exp_addr(i), "R3 R4 offset", 32'(wr_addr), 32'(exp_addr(i)));
      check(wr_data === w[8*(3 - (i % 4)) +: 8], "R5 R6 data byte",
            32'(wr_data), 32'(w[8*(3 - (i % 4)) +: 8]));
      if (mode == 1 && i == 3) begin
        os0[t] = ~os0[t]; os2[t] = 32'h0; pl2[t] = 32'h0; ph2[t] = 32'h0;
      end
      if (mode == 2 && i == 5) begin
        other = (t + 1) % NT;
        pull_req = 1; pull_thread = TW'(other);
      end
      if (mode == 2 && i == 6) pull_req = 0;
      @(negedge clk);
    end
    check(done === 1'b1, "R7 done after last byte", 32'(done), 1);
    check(wr_en === 1'b0, "R3 exactly 17 bytes", 32'(wr_en), 0);
    check(clr_os === NT'(1 << t), "R7 clear os strobe", 32'(clr_os), 32'(1 << t));
    check(clr_pool === NT'(1 << t), "R7 clear pool strobe", 32'(clr_pool), 32'(1 << t));
    check(clr_phys === NT'(1 << t), "R7 clear phys strobe", 32'(clr_phys), 32'(1 << t));
    for (int k = 0; k < NT; k++) begin
      if (clr_os[k])   os2[k][31] = 1'b0;
      if (clr_pool[k]) pl2[k][31] = 1'b0;
      if (clr_phys[k]) ph2[k][31] = 1'b0;
    end
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R7 idle after done", {busy, done}, 0);
    check(clr_os === '0, "R7 strobe single cycle", 32'(clr_os), 0);
  endtask

  task automatic test_reset;
    check(busy === 0 && wr_en === 0 && done === 0, "R1 reset outputs",
          {busy, wr_en, done}, 0);
    check(clr_os === 0 && clr_pool === 0 && clr_phys === 0, "R1 reset strobes",
          {clr_os, clr_pool, clr_phys}, 0);
  endtask

  task automatic test_basic;
    load_ctx(1, 32'h11223344, 32'h8055AA01, 32'h80C0FFEE, 32'h01FF00FF, 32'h80000000);
    run_pull(1, 0);
    check(os2[1][31] === 0, "R8 os valid cleared", 32'(os2[1][31]), 0);
    check(pl2[1][31] === 0, "R8 pool valid cleared", 32'(pl2[1][31]), 0);
    check(ph2[1][31] === 0, "R8 phys valid cleared", 32'(ph2[1][31]), 0);
    check(os2[0][31] === 1, "R7 other thread untouched", 32'(os2[0][31]), 1);
  endtask

  task automatic test_edges;
    load_ctx(0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_pull(0, 0);
    load_ctx(3, 32'hA1B2C3D4, 32'h80E5F607, 32'h8F1E2D3C, 32'h4B5A6978, 32'h87654321);
    run_pull(3, 0);
    check(ph2[3] === 32'h07654321, "R8 phys valid only bit cleared", ph2[3], 32'h07654321);
  endtask

  task automatic test_snapshot;
    load_ctx(2, 32'hCAFE0102, 32'h80BEEF03, 32'h80D00D04, 32'h600DF00D, 32'h80123456);
    run_pull(2, 1);
  endtask

  task automatic test_busy_ignore;
    load_ctx(1, 32'h0A0B0C0D, 32'h80000081, 32'h80000082, 32'h00FF00FF, 32'h80ABCDEF);
    run_pull(1, 2);
    for (int k = 0; k < 4; k++) begin
      check(wr_en === 0 && busy === 0, "R9 no extra pull", {wr_en, busy}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < NT; i++) load_ctx(i, 32'h0, 32'h80000000, 32'h80000000, 32'h0, 32'h80000000);
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_basic();
    test_edges();
    test_snapshot();
    test_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule